// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one transmit-style DMA channel. Its work is described by a chain of four-word descriptors that sit in system memory. Software builds the chain and hands each descriptor to the channel by setting its ownership bit. It then writes the address of the first descriptor and sets a go bit in the control register. The channel walks the chain, one descriptor at a time. For each descriptor it reads the buffer one 32-bit word per beat and presents the words on a stream output for a downstream consumer. It then rewrites the descriptor's first word to return it to software. That word carries the descriptor count of the frame and any error flags.

Frames are delimited by a two-bit first/last field in the link word. The channel raises end-of-frame, protocol-error and data-error status bits, which software clears by writing ones. A level interrupt follows those bits, each gated by its own enable. If the channel meets a descriptor that software still owns, it parks there. A later resume command makes it fetch that same descriptor again, without restarting the frame.

Descriptor layout, in byte offsets from the 16-byte aligned base:
- Word 0 (+0) is frame control. Bits [15:0] give the buffer length in words. Bits [23:16] hold the count written back. Bit 27 is the protocol-error flag, bit 28 the data-error flag and bit 31 the ownership bit.
- Word 1 (+4) is reserved. The channel never reads it.
- Word 2 (+8) is the buffer byte address.
- Word 3 (+12) is the link word. Bit 0 marks the last descriptor of a frame and bit 1 the first. Bit 2 selects the address direction, bit 3 enables the end-of-frame interrupt, and bits [31:4] hold the next descriptor address.

The channel has four registers, selected by `reg_addr`:
- 0: control.
- 1: status.
- 2: first descriptor address.
- 3: current descriptor address, which is read-only.

`reg_rdata` shows the register that `reg_addr` selected at the previous clock edge.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, the status register reads 0x0000_0001: bit 0 (idle) is 1 and every other bit is 0. `irq` is 0 and `mem_req` is 0.
- R2: A control write with bit 31 set copies the first-descriptor register into the current-descriptor register and starts a fetch there. The first-descriptor register reads back the value written to it. The current-descriptor register always reads the address of the descriptor being worked on, or of the one the channel stopped at.
- R3: The channel processes a descriptor only if bit 31 of word 0 is 1. If that bit is 0, the channel goes idle with the current address pointing at that descriptor. It writes nothing to the descriptor and emits no data.
- R4: For a descriptor of length N (word 0 bits [15:0]), the channel reads N words starting at the word 2 address and emits each word once on `strm_data` with `strm_valid`. The address steps by +4 when link bit 2 is 0 and by −4 when it is 1.
- R5: When a descriptor is finished, word 0 is rewritten. The ownership bit becomes 0 and the length is kept. Bits [23:16] hold the descriptor count within the frame: 1 for a descriptor with the first flag, otherwise one more than the previous descriptor. Bit 27 reports a protocol error and bit 28 a data error.
- R6: With control bit 29 (chain) set, the channel goes on to the descriptor at link bits [31:4]×16. With it clear, the channel stops after one descriptor.
- R7: A control write with bit 30 set while the channel is idle fetches the current descriptor again. The open-frame state and the descriptor count are kept.
- R8: After a descriptor with link bit 0 (last) is written back, status bit 27 is set. That bit raises `irq` only if link bit 3 of that descriptor was 1.
- R9: Status bits 27, 29 and 30 are cleared by writing 1 to them. Writing 0 leaves them unchanged. `irq` falls once its cause is cleared.
- R10: An error response on a buffer read stops the data and sets the data-error flag in the written-back word 0. It also sets status bit 30 and halts the channel without following the link. `irq` rises if control bit 17 is set.
- R11: Link bit 1 (first) must be 1 exactly when no frame is open. On a mismatch, no data is moved, the protocol-error flag is written back and status bit 29 is set. The channel then halts, and `irq` rises if control bit 16 is set.
- R12: A descriptor of length 0 is written back with no data beats and otherwise follows the normal flow.
- R13: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the register selected at the last edge |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_err | input | 1 | Error response, qualified by mem_ack |
| mem_rdata | input | 32 | Read data |
| strm_valid | output | 1 | Buffer word valid, one cycle per word |
| strm_data | output | 32 | Buffer word |
| irq | output | 1 | Interrupt level |

## Verification
Each buffer word holds a pattern derived from its own address, so the emitted stream shows the exact address order. That separates incrementing from decrementing buffers and shows which descriptors were actually visited. The test chains are chosen to tell cases apart:
- A three-descriptor chain checks that the count rises across a frame.
- A chain with chain mode off checks that the second descriptor keeps its ownership bit.
- A park-then-resume sequence checks that the count carries across a resume.
- An injected error address, a middle descriptor with no open frame, and a zero-length descriptor each give their own written-back word, status value and interrupt level. These are compared against values worked out by hand.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W = 32;
  localparam int SIZE_W = 16;
  localparam int CNT_W  = 8;

  // control register fields
  localparam int CTL_GO      = 31;
  localparam int CTL_RESUME  = 30;
  localparam int CTL_CHAIN   = 29;
  localparam int CTL_IE_FAIL = 17;
  localparam int CTL_IE_PERR = 16;

  // status register fields
  localparam int ST_IDLE = 0;
  localparam int ST_EOF  = 27;
  localparam int ST_PERR = 29;
  localparam int ST_DERR = 30;

  // descriptor word 0 fields
  localparam int D0_CNT_LSB = 16;
  localparam int D0_PERR    = 27;
  localparam int D0_DERR    = 28;
  localparam int D0_OWN     = 31;

  // descriptor link word fields
  localparam int LK_LAST  = 0;
  localparam int LK_FIRST = 1;
  localparam int LK_DEC   = 2;
  localparam int LK_EOFIE = 3;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_FIRST = 2'd2;
  localparam logic [1:0] RA_CUR   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CTRL, S_RD_BUF, S_RD_LINK, S_CHECK, S_XFER, S_WB
  } chan_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic              idle,
  input  logic              ev_eof,
  input  logic              ev_eof_irq,
  input  logic              ev_perr,
  input  logic              ev_derr,
  output logic              go,
  output logic              resume,
  output logic              chain_en,
  output logic              ie_fail,
  output logic              ie_perr,
  output logic [WORD_W-1:0] first_addr,
  output logic              st_eof,
  output logic              st_perr,
  output logic              st_derr,
  output logic              eof_pend
);
  logic ctl_wr, stat_wr;
  logic clr_eof, clr_perr, clr_derr;

  assign ctl_wr   = reg_we && (reg_addr == RA_CTRL);
  assign stat_wr  = reg_we && (reg_addr == RA_STAT);
  assign go       = ctl_wr && reg_wdata[CTL_GO];
  assign resume   = ctl_wr && reg_wdata[CTL_RESUME] && !reg_wdata[CTL_GO];
  assign clr_eof  = stat_wr && reg_wdata[ST_EOF];
  assign clr_perr = stat_wr && reg_wdata[ST_PERR];
  assign clr_derr = stat_wr && reg_wdata[ST_DERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_en   <= 1'b0;
      ie_fail    <= 1'b0;
      ie_perr    <= 1'b0;
      first_addr <= '0;
      st_eof     <= 1'b0;
      st_perr    <= 1'b0;
      st_derr    <= 1'b0;
      eof_pend   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        chain_en <= reg_wdata[CTL_CHAIN];
        ie_fail  <= reg_wdata[CTL_IE_FAIL];
        ie_perr  <= reg_wdata[CTL_IE_PERR];
      end
      if (reg_we && (reg_addr == RA_FIRST))
        first_addr <= {reg_wdata[WORD_W-1:4], 4'b0000};
      // a new event wins over a clear in the same cycle
      st_eof   <= ev_eof  | (st_eof  & ~clr_eof);
      st_perr  <= ev_perr | (st_perr & ~clr_perr);
      st_derr  <= ev_derr | (st_derr & ~clr_derr);
      eof_pend <= (ev_eof & ev_eof_irq) | (eof_pend & ~clr_eof);
    end
  end

  logic [WORD_W-1:0] ctl_view, stat_view;
  always_comb begin
    ctl_view              = '0;
    ctl_view[CTL_CHAIN]   = chain_en;
    ctl_view[CTL_IE_FAIL] = ie_fail;
    ctl_view[CTL_IE_PERR] = ie_perr;
    stat_view             = '0;
    stat_view[ST_IDLE]    = idle;
    stat_view[ST_EOF]     = st_eof;
    stat_view[ST_PERR]    = st_perr;
    stat_view[ST_DERR]    = st_derr;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= ctl_view;
        RA_STAT:  reg_rdata <= stat_view;
        RA_FIRST: reg_rdata <= first_addr;
        default:  reg_rdata <= cur_addr;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              resume,
  input  logic              chain_en,
  input  logic [WORD_W-1:0] first_addr,
  output logic [WORD_W-1:0] cur_addr,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              strm_valid,
  output logic [WORD_W-1:0] strm_data,
  output logic              ev_eof,
  output logic              ev_eof_irq,
  output logic              ev_perr,
  output logic              ev_derr
);
  chan_state_t       state;
  logic [SIZE_W-1:0] d_size;
  logic [SIZE_W-1:0] remain;
  logic [WORD_W-1:0] d_buf;
  logic [WORD_W-1:0] d_link;
  logic [WORD_W-1:0] beat_addr;
  logic [CNT_W-1:0]  frame_cnt;
  logic              frame_open;
  logic              err_p, err_d;

  logic [WORD_W-1:0] link_next;
  logic [WORD_W-1:0] beat_next;
  assign link_next = {d_link[WORD_W-1:4], 4'b0000};
  assign beat_next = d_link[LK_DEC] ? (beat_addr - WORD_W'(4)) : (beat_addr + WORD_W'(4));

  // writeback word is assembled from the held descriptor fields
  always_comb begin
    mem_wdata                         = '0;
    mem_wdata[SIZE_W-1:0]             = d_size;
    mem_wdata[D0_CNT_LSB +: CNT_W]    = frame_cnt;
    mem_wdata[D0_PERR]                = err_p;
    mem_wdata[D0_DERR]                = err_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idle       <= 1'b1;
      cur_addr   <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      d_size     <= '0;
      remain     <= '0;
      d_buf      <= '0;
      d_link     <= '0;
      beat_addr  <= '0;
      frame_cnt  <= '0;
      frame_open <= 1'b0;
      err_p      <= 1'b0;
      err_d      <= 1'b0;
      strm_valid <= 1'b0;
      strm_data  <= '0;
      ev_eof     <= 1'b0;
      ev_eof_irq <= 1'b0;
      ev_perr    <= 1'b0;
      ev_derr    <= 1'b0;
    end else begin
      strm_valid <= 1'b0;
      ev_eof     <= 1'b0;
      ev_eof_irq <= 1'b0;
      ev_perr    <= 1'b0;
      ev_derr    <= 1'b0;
      case (state)
        S_IDLE: begin
          mem_we <= 1'b0;
          err_p  <= 1'b0;
          err_d  <= 1'b0;
          if (go) begin
            cur_addr   <= first_addr;
            mem_addr   <= first_addr;
            mem_req    <= 1'b1;
            frame_open <= 1'b0;
            frame_cnt  <= '0;
            idle       <= 1'b0;
            state      <= S_RD_CTRL;
          end else if (resume) begin
            mem_addr <= cur_addr;
            mem_req  <= 1'b1;
            idle     <= 1'b0;
            state    <= S_RD_CTRL;
          end
        end
        S_RD_CTRL: if (mem_ack) begin
          if (mem_err) begin
            ev_derr <= 1'b1;
            mem_req <= 1'b0;
            idle    <= 1'b1;
            state   <= S_IDLE;
          end else if (!mem_rdata[D0_OWN]) begin
            mem_req <= 1'b0;
            idle    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            d_size   <= mem_rdata[SIZE_W-1:0];
            mem_addr <= cur_addr + WORD_W'(8);
            state    <= S_RD_BUF;
          end
        end
        S_RD_BUF: if (mem_ack) begin
          if (mem_err) begin
            ev_derr <= 1'b1;
            mem_req <= 1'b0;
            idle    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            d_buf    <= mem_rdata;
            mem_addr <= cur_addr + WORD_W'(12);
            state    <= S_RD_LINK;
          end
        end
        S_RD_LINK: if (mem_ack) begin
          mem_req <= 1'b0;
          if (mem_err) begin
            ev_derr <= 1'b1;
            idle    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            d_link <= mem_rdata;
            state  <= S_CHECK;
          end
        end
        S_CHECK: begin
          frame_cnt <= d_link[LK_FIRST] ? CNT_W'(1) : frame_cnt + CNT_W'(1);
          mem_req   <= 1'b1;
          if (d_link[LK_FIRST] == frame_open) begin
            err_p    <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= cur_addr;
            state    <= S_WB;
          end else if (d_size == '0) begin
            mem_we   <= 1'b1;
            mem_addr <= cur_addr;
            state    <= S_WB;
          end else begin
            remain    <= d_size;
            beat_addr <= d_buf;
            mem_addr  <= d_buf;
            state     <= S_XFER;
          end
        end
        S_XFER: if (mem_ack) begin
          if (mem_err) begin
            err_d    <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= cur_addr;
            state    <= S_WB;
          end else begin
            strm_valid <= 1'b1;
            strm_data  <= mem_rdata;
            remain     <= remain - SIZE_W'(1);
            if (remain == SIZE_W'(1)) begin
              mem_we   <= 1'b1;
              mem_addr <= cur_addr;
              state    <= S_WB;
            end else begin
              beat_addr <= beat_next;
              mem_addr  <= beat_next;
            end
          end
        end
        S_WB: if (mem_ack) begin
          mem_we <= 1'b0;
          if (err_p || err_d) begin
            ev_perr    <= err_p;
            ev_derr    <= err_d;
            frame_open <= 1'b0;
            mem_req    <= 1'b0;
            idle       <= 1'b1;
            state      <= S_IDLE;
          end else begin
            frame_open <= !d_link[LK_LAST];
            ev_eof     <= d_link[LK_LAST];
            ev_eof_irq <= d_link[LK_LAST] && d_link[LK_EOFIE];
            if (chain_en) begin
              cur_addr <= link_next;
              mem_addr <= link_next;
              state    <= S_RD_CTRL;
            end else begin
              mem_req <= 1'b0;
              idle    <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end
        default: begin
          mem_req <= 1'b0;
          idle    <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq (
  input  logic clk,
  input  logic rst,
  input  logic st_eof,
  input  logic eof_pend,
  input  logic st_perr,
  input  logic ie_perr,
  input  logic st_derr,
  input  logic ie_fail,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (st_eof & eof_pend) | (st_perr & ie_perr) | (st_derr & ie_fail);
  end
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              strm_valid,
  output logic [31:0]       strm_data,
  output logic              irq
);
  logic              go, resume, chain_en, ie_fail, ie_perr;
  logic [WORD_W-1:0] first_addr, cur_addr;
  logic              idle;
  logic              ev_eof, ev_eof_irq, ev_perr, ev_derr;
  logic              st_eof, st_perr, st_derr, eof_pend;

  dma_chan_regs u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr[1:0]), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_addr(cur_addr), .idle(idle),
    .ev_eof(ev_eof), .ev_eof_irq(ev_eof_irq), .ev_perr(ev_perr), .ev_derr(ev_derr),
    .go(go), .resume(resume), .chain_en(chain_en), .ie_fail(ie_fail), .ie_perr(ie_perr),
    .first_addr(first_addr),
    .st_eof(st_eof), .st_perr(st_perr), .st_derr(st_derr), .eof_pend(eof_pend)
  );

  dma_chan_engine u_eng (
    .clk(clk), .rst(rst),
    .go(go), .resume(resume), .chain_en(chain_en), .first_addr(first_addr),
    .cur_addr(cur_addr), .idle(idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .strm_valid(strm_valid), .strm_data(strm_data),
    .ev_eof(ev_eof), .ev_eof_irq(ev_eof_irq), .ev_perr(ev_perr), .ev_derr(ev_derr)
  );

  dma_chan_irq u_irq (
    .clk(clk), .rst(rst),
    .st_eof(st_eof), .eof_pend(eof_pend),
    .st_perr(st_perr), .ie_perr(ie_perr),
    .st_derr(st_derr), .ie_fail(ie_fail),
    .irq(irq)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        strm_valid,
  input logic        idle,
  input logic        irq,
  input logic        st_eof,
  input logic        st_perr,
  input logic        st_derr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]); // R5
  AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[3:0] == 4'h0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mem_req); // R3
  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (rst)
    strm_valid |=> !strm_valid); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(st_eof || st_perr || st_derr)); // R8
endmodule

bind desc_dma_chan dma_chan_chk u_chk (
  .clk(clk), .rst(rst),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .strm_valid(strm_valid), .idle(idle), .irq(irq),
  .st_eof(st_eof), .st_perr(st_perr), .st_derr(st_derr)
);

// File: tb/desc_dma_chan_test.sv
module desc_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        strm_valid;
  logic [31:0] strm_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  desc_dma_chan uut (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .strm_valid(strm_valid), .strm_data(strm_data), .irq(irq)
  );

  // behavioural memory: one request served per acknowledge
  logic [31:0] mem [0:1023];
  logic        bwr_en = 1'b0;
  logic [31:0] bwr_addr = '0;
  logic [31:0] bwr_data = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(32'(i * 4));
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (bwr_en) mem[bwr_addr[11:2]] <= bwr_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else begin
          mem_rdata <= mem[mem_addr[11:2]];
          mem_err   <= (mem_addr == err_addr);
        end
      end
    end
  end

  // reference stream: expected words in order, compared on every clock
  logic [31:0] exp_q[$];

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && strm_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected beat actual=%h expected=none", strm_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (strm_data !== e) begin
          errors++;
          $display("FAIL R4 stream actual=%h expected=%h", strm_data, e);
        end
      end
    end
  end

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bwr_en = 1'b1; bwr_addr = a; bwr_data = d;
    @(negedge clk);
    bwr_en = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] base, input logic own, input logic [15:0] len,
                          input logic [31:0] bufa, input logic [1:0] fl, input logic dec,
                          input logic eofie, input logic [31:0] nxt);
    put_word(base,      {own, 15'b0, len});
    put_word(base + 4,  32'h0);
    put_word(base + 8,  bufa);
    put_word(base + 12, {nxt[31:4], eofie, dec, fl});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n;
    n = 0;
    s = '0;
    while (!s[0] && n < 3000) begin
      rd(2'd1, s);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic q_empty(input string tag);
    chk32(tag, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v);
    chk32("R1 status", v, 32'h0000_0001);
    chk32("R1 irq", {31'b0, irq}, 32'd0);
    chk32("R1 mem_req", {31'b0, mem_req}, 32'd0);

    // R2 R4 R5 R6 R8: three-descriptor frame, incrementing
    set_desc(32'h100, 1'b1, 16'd3, 32'h400, 2'b10, 1'b0, 1'b0, 32'h140);
    set_desc(32'h140, 1'b1, 16'd2, 32'h500, 2'b00, 1'b0, 1'b0, 32'h180);
    set_desc(32'h180, 1'b1, 16'd1, 32'h600, 2'b01, 1'b0, 1'b1, 32'h1C0);
    put_word(32'h1C0, 32'h0000_0004);
    exp_q.push_back(pat(32'h400)); exp_q.push_back(pat(32'h404));
    exp_q.push_back(pat(32'h408)); exp_q.push_back(pat(32'h500));
    exp_q.push_back(pat(32'h504)); exp_q.push_back(pat(32'h600));
    wr(2'd2, 32'h100);
    rd(2'd2, v);
    chk32("R2 first reg", v, 32'h100);
    wr(2'd0, 32'hA000_0000);
    wait_idle();
    q_empty("R4 frame stream");
    chk32("R5 wb d0", mem[32'h100 >> 2], 32'h0001_0003);
    chk32("R5 wb d1", mem[32'h140 >> 2], 32'h0002_0002);
    chk32("R5 wb d2", mem[32'h180 >> 2], 32'h0003_0001);
    chk32("R3 cpu owned untouched", mem[32'h1C0 >> 2], 32'h0000_0004);
    rd(2'd3, v);
    chk32("R6 R2 current reg", v, 32'h1C0);
    rd(2'd1, v);
    chk32("R8 status eof", v, 32'h0800_0001);
    chk32("R8 irq with eofie", {31'b0, irq}, 32'd1);
    rd(2'd0, v);
    chk32("R6 ctrl readback", v, 32'h2000_0000);

    // R9 write-one-to-clear
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v);
    chk32("R9 zero write keeps", v, 32'h0800_0001);
    wr(2'd1, 32'h0800_0000);
    rd(2'd1, v);
    chk32("R9 cleared", v, 32'h0000_0001);
    chk32("R9 irq low", {31'b0, irq}, 32'd0);

    // R4 R8: decrementing single descriptor, no end-of-frame interrupt
    set_desc(32'h200, 1'b1, 16'd3, 32'h70C, 2'b11, 1'b1, 1'b0, 32'h240);
    exp_q.push_back(pat(32'h70C)); exp_q.push_back(pat(32'h708));
    exp_q.push_back(pat(32'h704));
    wr(2'd2, 32'h200);
    wr(2'd0, 32'h8000_0000);
    wait_idle();
    q_empty("R4 decrement stream");
    chk32("R5 wb single", mem[32'h200 >> 2], 32'h0001_0003);
    rd(2'd1, v);
    chk32("R8 eof without ie", v, 32'h0800_0001);
    chk32("R8 irq masked", {31'b0, irq}, 32'd0);
    wr(2'd1, 32'h0800_0000);

    // R6 chain off: second descriptor not taken
    set_desc(32'h240, 1'b1, 16'd1, 32'h800, 2'b10, 1'b0, 1'b0, 32'h280);
    set_desc(32'h280, 1'b1, 16'd1, 32'h804, 2'b01, 1'b0, 1'b0, 32'h2C0);
    exp_q.push_back(pat(32'h800));
    wr(2'd2, 32'h240);
    wr(2'd0, 32'h8000_0000);
    wait_idle();
    q_empty("R6 one descriptor");
    chk32("R6 first wb", mem[32'h240 >> 2], 32'h0001_0001);
    chk32("R6 second still owned", mem[32'h280 >> 2], 32'h8000_0001);
    rd(2'd3, v);
    chk32("R6 current stays", v, 32'h240);

    // R3 R7: park on cpu-owned descriptor, then resume inside the frame
    set_desc(32'h2C0, 1'b1, 16'd1, 32'h880, 2'b10, 1'b0, 1'b0, 32'h300);
    put_word(32'h300, 32'h0000_0002);
    exp_q.push_back(pat(32'h880));
    wr(2'd2, 32'h2C0);
    wr(2'd0, 32'hA000_0000);
    wait_idle();
    q_empty("R3 park stream");
    rd(2'd3, v);
    chk32("R3 parked address", v, 32'h300);
    chk32("R3 no writeback", mem[32'h300 >> 2], 32'h0000_0002);
    set_desc(32'h300, 1'b1, 16'd2, 32'h890, 2'b01, 1'b0, 1'b1, 32'h340);
    put_word(32'h340, 32'h0000_0000);
    exp_q.push_back(pat(32'h890)); exp_q.push_back(pat(32'h894));
    wr(2'd0, 32'h6000_0000);
    wait_idle();
    q_empty("R7 resume stream");
    chk32("R7 count continues", mem[32'h300 >> 2], 32'h0002_0002);
    rd(2'd3, v);
    chk32("R7 current after", v, 32'h340);
    rd(2'd1, v);
    chk32("R7 R8 status", v, 32'h0800_0001);
    wr(2'd1, 32'h0800_0000);

    // R10 data error on the second buffer word
    set_desc(32'h380, 1'b1, 16'd3, 32'hA00, 2'b11, 1'b0, 1'b0, 32'h3C0);
    set_desc(32'h3C0, 1'b1, 16'd1, 32'hA40, 2'b11, 1'b0, 1'b0, 32'h000);
    err_addr = 32'hA04;
    exp_q.push_back(pat(32'hA00));
    wr(2'd2, 32'h380);
    wr(2'd0, 32'hA002_0000);
    wait_idle();
    q_empty("R10 stream stops");
    chk32("R10 wb derr", mem[32'h380 >> 2], 32'h1001_0003);
    chk32("R10 link not taken", mem[32'h3C0 >> 2], 32'h8000_0001);
    rd(2'd1, v);
    chk32("R10 status", v, 32'h4000_0001);
    chk32("R10 irq", {31'b0, irq}, 32'd1);
    rd(2'd3, v);
    chk32("R10 current", v, 32'h380);
    wr(2'd1, 32'h4000_0000);
    rd(2'd1, v);
    chk32("R9 derr cleared", v, 32'h0000_0001);
    chk32("R9 irq after derr clear", {31'b0, irq}, 32'd0);
    err_addr = 32'hFFFF_FFFF;

    // R11 middle descriptor with no open frame
    set_desc(32'h3C0, 1'b1, 16'd2, 32'hA40, 2'b00, 1'b0, 1'b0, 32'h000);
    wr(2'd2, 32'h3C0);
    wr(2'd0, 32'hA001_0000);
    wait_idle();
    q_empty("R11 no data");
    chk32("R11 wb perr", mem[32'h3C0 >> 2], 32'h0801_0002);
    rd(2'd1, v);
    chk32("R11 status", v, 32'h2000_0001);
    chk32("R11 irq", {31'b0, irq}, 32'd1);
    wr(2'd1, 32'h2000_0000);
    rd(2'd1, v);
    chk32("R9 perr cleared", v, 32'h0000_0001);

    // R12 zero-length descriptor
    set_desc(32'h040, 1'b1, 16'd0, 32'h900, 2'b11, 1'b0, 1'b1, 32'h080);
    wr(2'd2, 32'h040);
    wr(2'd0, 32'h8000_0000);
    wait_idle();
    q_empty("R12 no beats");
    chk32("R12 wb", mem[32'h040 >> 2], 32'h0001_0000);
    rd(2'd1, v);
    chk32("R12 status", v, 32'h0800_0001);
    chk32("R12 irq", {31'b0, irq}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule